// File: doc/BRIEF.md
# Bus Cycle Trace Recorder

This block observes a 68000-style bus (24-bit address, 16-bit data, an active-low read strobe and two active-low byte write strobes) and turns every finished bus cycle into a five-word trace record. A record carries a free-running cycle timestamp, the access kind, the address split into two words, and the data word. Records are packed into blocks of `BLOCK_RECS` entries, held in two alternating banks of one inferred dual-port memory, and handed downstream as a valid/ready stream of 16-bit words. All bus inputs are assumed to be synchronous to the capture clock already.

A block is streamed out only once it holds a full set of records. While the bus is quiet the partial block stays inside, so the output can wait forever. Only one bank can be filling at a time, so capture goes on while the other bank drains. When both banks are full and still waiting, new records are thrown away and a sticky overflow flag is raised.

Top module: `bus_trace_capture`

## Requirements
- R1: Each record leaves as five words in this order: timestamp, access kind, upper address word (address bits above 15, zero-extended), lower address word (address bits 15..0), data word.
- R2: The access kind word holds the code in bits 1..0 with bits 15..2 zero. Code 0 is a read (only the read strobe was low). Code 1 means only the upper-byte write strobe was low. Code 2 means only the lower-byte write strobe was low. Code 3 means both write strobes were low.
- R3: A bus cycle is a run of consecutive clocks in which at least one strobe is low. It produces exactly one record, however many clocks it lasts, and that record is committed on the first clock in which all strobes are high again.
- R4: Address and data in a record are the values present on the last clock in which a strobe was low. Values present on the release clock or later have no effect on it.
- R5: The timestamp counts clock cycles. The difference between the timestamps of two consecutive records, modulo 2^16, equals the number of clocks between their strobe releases.
- R6: No word of a block is offered until all `BLOCK_RECS` records of that block are captured. A partial block is held back however long the bus stays idle.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R8: Two banks alternate. A second block is captured while the first is still waiting, and records leave in capture order across blocks.
- R9: A record that finishes while both banks are full is dropped and never appears on the output. The overflow output then goes high and stays high until reset.
- R10: After reset out_valid and overflow are low and both banks are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Bus address |
| bus_data | input | 16 | Bus data word |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_hi_n | input | 1 | Upper-byte write strobe, active low |
| bus_wr_lo_n | input | 1 | Lower-byte write strobe, active low |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 16 | Stream word |
| overflow | output | 1 | Sticky record-drop flag |

## Verification
The assertions assume that the strobes are clean synchronous levels with no one-clock glitch inside a cycle. They also assume that a read and a write never overlap in one cycle, and that the downstream side does not need out_data to be defined while out_valid is low. The stimulus drives every input one nanosecond after a rising edge. It holds each strobe pattern for a whole number of clocks, puts at least one idle clock between bus cycles, and never mixes read and write strobes. At every release it puts junk on address and data, so any sampling on the wrong clock shows up in the records.

// File: rtl/bus_trace_pkg.sv
package bus_trace_pkg;
  localparam int WORD_W    = 16;
  localparam int REC_WORDS = 5;
  localparam int REC_W     = WORD_W * REC_WORDS;

  typedef enum logic [1:0] {
    ACC_READ    = 2'd0,
    ACC_WR_HI   = 2'd1,
    ACC_WR_LO   = 2'd2,
    ACC_WR_WORD = 2'd3
  } acc_kind_t;

  // a write lane seen anywhere in the cycle makes it a write
  function automatic acc_kind_t classify(input logic saw_hi, input logic saw_lo);
    if (saw_hi || saw_lo) return acc_kind_t'({saw_lo, saw_hi});
    return ACC_READ;
  endfunction
endpackage

// File: rtl/bus_trace_decode.sv
module bus_trace_decode
  import bus_trace_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd_n,
  input  logic              bus_wr_hi_n,
  input  logic              bus_wr_lo_n,
  output logic              rec_valid,
  output logic [REC_W-1:0]  rec_word
);
  localparam int AEXT_W = 32;

  logic              act_in, act_q;
  logic              saw_hi, saw_lo;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [TS_W-1:0]   ts;
  logic [AEXT_W-1:0] addr_ext;
  acc_kind_t         kind;

  assign act_in   = !bus_rd_n || !bus_wr_hi_n || !bus_wr_lo_n;
  assign addr_ext = AEXT_W'(lat_addr);
  assign kind     = classify(saw_hi, saw_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      saw_hi    <= 1'b0;
      saw_lo    <= 1'b0;
      lat_addr  <= '0;
      lat_data  <= '0;
      ts        <= '0;
      rec_valid <= 1'b0;
      rec_word  <= '0;
    end else begin
      ts        <= ts + 1'b1;
      act_q     <= act_in;
      rec_valid <= 1'b0;
      if (act_in) begin
        lat_addr <= bus_addr;
        lat_data <= bus_data;
        if (act_q) begin
          saw_hi <= saw_hi | !bus_wr_hi_n;
          saw_lo <= saw_lo | !bus_wr_lo_n;
        end else begin
          saw_hi <= !bus_wr_hi_n;
          saw_lo <= !bus_wr_lo_n;
        end
      end
      if (act_q && !act_in) begin
        rec_valid <= 1'b1;
        rec_word  <= {WORD_W'(ts),
                      WORD_W'(kind),
                      addr_ext[2*WORD_W-1:WORD_W],
                      addr_ext[WORD_W-1:0],
                      WORD_W'(lat_data)};
      end
    end
  end
endmodule

// File: rtl/bus_trace_banks.sv
module bus_trace_banks #(
  parameter int BLOCK_RECS = 64,
  parameter int IDX_W      = $clog2(BLOCK_RECS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rec_valid,
  input  logic           release_blk,
  input  logic           rel_bank,
  output logic           wr_en,
  output logic [IDX_W:0] wr_addr,
  output logic [1:0]     bank_full,
  output logic           wr_bank,
  output logic           overflow
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_RECS - 1);

  logic [IDX_W-1:0] wr_idx;

  assign wr_en   = rec_valid && !bank_full[wr_bank];
  assign wr_addr = {wr_bank, wr_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_full <= 2'b00;
      wr_bank   <= 1'b0;
      wr_idx    <= '0;
      overflow  <= 1'b0;
    end else begin
      // release and fill never touch the same bank in one cycle
      if (release_blk) bank_full[rel_bank] <= 1'b0;
      if (rec_valid) begin
        if (bank_full[wr_bank]) begin
          overflow <= 1'b1;
        end else if (wr_idx == LAST_IDX) begin
          bank_full[wr_bank] <= 1'b1;
          wr_bank            <= ~wr_bank;
          wr_idx             <= '0;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bus_trace_ram.sv
module bus_trace_ram #(
  parameter int WIDTH = 80,
  parameter int AW    = 7,
  parameter int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bus_trace_serial.sv
module bus_trace_serial
  import bus_trace_pkg::*;
#(
  parameter int BLOCK_RECS = 64,
  parameter int IDX_W      = $clog2(BLOCK_RECS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bank_full,
  input  logic [REC_W-1:0]  rdata,
  output logic              re,
  output logic [IDX_W:0]    raddr,
  output logic              release_blk,
  output logic              rel_bank,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(BLOCK_RECS - 1);
  localparam int               CNT_W     = $clog2(REC_WORDS);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(REC_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} ser_state_t;

  ser_state_t       st;
  logic             rd_bank;
  logic [IDX_W-1:0] rec_idx;
  logic [CNT_W-1:0] wcnt;
  logic [REC_W-1:0] sh;
  logic             last_word_go;

  assign re           = (st == S_IDLE) && bank_full[rd_bank];
  assign raddr        = {rd_bank, rec_idx};
  assign out_data     = sh[REC_W-1 -: WORD_W];
  assign last_word_go = (st == S_SEND) && out_ready && (wcnt == LAST_WORD);
  assign release_blk  = last_word_go && (rec_idx == LAST_IDX);
  assign rel_bank     = rd_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      rd_bank   <= 1'b0;
      rec_idx   <= '0;
      wcnt      <= '0;
      sh        <= '0;
      out_valid <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (re) st <= S_WAIT;
        S_WAIT: begin
          sh        <= rdata;
          wcnt      <= '0;
          out_valid <= 1'b1;
          st        <= S_SEND;
        end
        S_SEND: if (out_ready) begin
          if (wcnt == LAST_WORD) begin
            out_valid <= 1'b0;
            st        <= S_IDLE;
            if (rec_idx == LAST_IDX) begin
              rec_idx <= '0;
              rd_bank <= ~rd_bank;
            end else begin
              rec_idx <= rec_idx + 1'b1;
            end
          end else begin
            sh   <= {sh[REC_W-WORD_W-1:0], WORD_W'(0)};
            wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_trace_capture.sv
module bus_trace_capture
  import bus_trace_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int TS_W       = 16,
  parameter int BLOCK_RECS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd_n,
  input  logic              bus_wr_hi_n,
  input  logic              bus_wr_lo_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              overflow
);
  localparam int IDX_W = $clog2(BLOCK_RECS);
  localparam int AW    = IDX_W + 1;

  logic             rec_valid;
  logic [REC_W-1:0] rec_word;
  logic             wr_en, re;
  logic [AW-1:0]    wr_addr, raddr;
  logic [1:0]       bank_full;
  logic             wr_bank;
  logic             release_blk, rel_bank;
  logic [REC_W-1:0] rdata;

  bus_trace_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W)) u_decode (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd_n(bus_rd_n), .bus_wr_hi_n(bus_wr_hi_n), .bus_wr_lo_n(bus_wr_lo_n),
    .rec_valid(rec_valid), .rec_word(rec_word)
  );

  bus_trace_banks #(.BLOCK_RECS(BLOCK_RECS), .IDX_W(IDX_W)) u_banks (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .release_blk(release_blk),
    .rel_bank(rel_bank), .wr_en(wr_en), .wr_addr(wr_addr),
    .bank_full(bank_full), .wr_bank(wr_bank), .overflow(overflow)
  );

  bus_trace_ram #(.WIDTH(REC_W), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(rec_word),
    .re(re), .raddr(raddr), .rdata(rdata)
  );

  bus_trace_serial #(.BLOCK_RECS(BLOCK_RECS), .IDX_W(IDX_W)) u_serial (
    .clk(clk), .rst(rst), .bank_full(bank_full), .rdata(rdata),
    .re(re), .raddr(raddr), .release_blk(release_blk), .rel_bank(rel_bank),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/bus_trace_capture_chk.sv
module bus_trace_capture_chk (
  input logic        clk,
  input logic        rst,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data,
  input logic        overflow,
  input logic        rec_valid,
  input logic [1:0]  bank_full,
  input logic        wr_bank
);
  // R7: a stalled word is held
  a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6: nothing is offered unless a completed block is waiting
  a_r6_only_full_blocks: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (bank_full != 2'b00));

  // R9: a record meeting a full bank raises the flag
  a_r9_drop_flags: assert property (@(posedge clk) disable iff (rst)
    rec_valid && bank_full[wr_bank] |=> overflow);

  // R9: the flag never falls outside reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R10: reset empties everything
  a_r10_reset_state: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !overflow && bank_full == 2'b00);
endmodule

bind bus_trace_capture bus_trace_capture_chk u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .overflow(overflow), .rec_valid(rec_valid),
  .bank_full(bank_full), .wr_bank(wr_bank)
);

// File: tb/bus_trace_capture_test.sv
module bus_trace_capture_test;
  localparam int BLK = 4;
  localparam int NV  = 8;
  // {kind[45:44], addr[43:20], data[19:4], low clocks[3:0]}
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 24'h000000, 16'h00FF, 4'd2},
    {2'd0, 24'h000002, 16'hFE00, 4'd1},
    {2'd3, 24'hFF003E, 16'h0206, 4'd3},
    {2'd1, 24'hA14000, 16'h5345, 4'd2},
    {2'd2, 24'hA14001, 16'h4741, 4'd1},
    {2'd0, 24'hA10008, 16'h4AB9, 4'd5},
    {2'd3, 24'h00FDFE, 16'h020A, 4'd2},
    {2'd0, 24'h00020C, 16'h6606, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        bus_rd_n = 1'b1, bus_wr_hi_n = 1'b1, bus_wr_lo_n = 1'b1;
  logic        out_ready = 1'b0;
  logic        out_valid, overflow;
  logic [15:0] out_data;

  int total = 0, bad = 0, bcyc = 0, ngot = 0, nexp = 0;
  logic [15:0] got [128];
  logic [1:0]  ek  [32];
  logic [23:0] ea  [32];
  logic [15:0] ed  [32];
  int          er  [32];

  bus_trace_capture #(.BLOCK_RECS(BLK)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd_n(bus_rd_n), .bus_wr_hi_n(bus_wr_hi_n), .bus_wr_lo_n(bus_wr_lo_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .overflow(overflow)
  );

  always #2 clk = ~clk;
  always @(posedge clk) bcyc <= bcyc + 1;
  always @(negedge clk) if (!rst && out_valid && out_ready && ngot < 128) begin
    got[ngot] = out_data;
    ngot = ngot + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [45:0] v, input bit keep);
    @(posedge clk); #1;
    bus_addr = v[43:20];
    bus_data = v[19:4];
    bus_rd_n    = !(v[45:44] == 2'd0);
    bus_wr_hi_n = !v[44] || (v[45:44] == 2'd0) ? (v[45:44] == 2'd0 ? 1'b1 : !v[44]) : 1'b0;
    bus_wr_lo_n = !v[45];
    repeat (int'(v[3:0])) @(posedge clk);
    #1;
    bus_rd_n = 1'b1; bus_wr_hi_n = 1'b1; bus_wr_lo_n = 1'b1;
    bus_addr = 24'hFFFFFF; bus_data = 16'hDEAD;   // R4 junk on release
    if (keep) begin
      ek[nexp] = v[45:44]; ea[nexp] = v[43:20]; ed[nexp] = v[19:4]; er[nexp] = bcyc;
      nexp++;
    end
  endtask

  task automatic compare_run(input int nrec);
    check(ngot == nrec * 5, "R3 word count", ngot, nrec * 5);
    for (int r = 0; r < nrec && (r * 5 + 4) < ngot; r++) begin
      check(got[r*5+1] == {14'd0, ek[r]}, "R2 kind word", got[r*5+1], {14'd0, ek[r]});
      check(got[r*5+2] == {8'd0, ea[r][23:16]}, "R1 address high", got[r*5+2], ea[r][23:16]);
      check(got[r*5+3] == ea[r][15:0], "R1 R4 address low", got[r*5+3], ea[r][15:0]);
      check(got[r*5+4] == ed[r], "R4 R8 data word", got[r*5+4], ed[r]);
      if (r > 0)
        check(16'(got[r*5] - got[r*5-5]) == 16'(er[r] - er[r-1]), "R5 timestamp step",
              16'(got[r*5] - got[r*5-5]), 16'(er[r] - er[r-1]));
    end
  endtask

  task automatic drain(input int cycles);
    repeat (cycles) begin
      @(posedge clk); #1;
      out_ready = (bcyc % 3) != 0;   // R7 backpressure pattern
    end
    out_ready = 1'b0;
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check(out_valid == 0, "R10 valid in reset", out_valid, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(out_valid == 0, "R10 valid after reset", out_valid, 0);
    check(overflow == 0, "R10 overflow after reset", overflow, 0);

    // table walk: two full blocks with the sink stalled
    for (int v = 0; v < NV; v++) begin
      bus_cycle(VEC[v], 1'b1);
      if (v == BLK - 2) begin
        repeat (40) @(posedge clk); #1;
        check(out_valid == 0, "R6 partial block held", out_valid, 0);
      end
    end
    repeat (4) @(posedge clk); #1;
    check(out_valid == 1, "R6 full block offered", out_valid, 1);
    check(overflow == 0, "R8 two blocks fit", overflow, 0);
    drain(150);
    compare_run(NV);
    check(out_valid == 0, "R3 nothing extra", out_valid, 0);

    // overflow: nine records into eight slots
    ngot = 0; nexp = 0;
    for (int v = 0; v < 2 * BLK + 1; v++) bus_cycle(VEC[v % NV], v < 2 * BLK);
    repeat (3) @(posedge clk); #1;
    check(overflow == 1, "R9 overflow set", overflow, 1);
    drain(150);
    compare_run(2 * BLK);
    check(out_valid == 0, "R9 dropped record absent", out_valid, 0);

    // capture resumes after the drop, flag stays
    ngot = 0; nexp = 0;
    out_ready = 1'b1;
    for (int v = 0; v < BLK; v++) bus_cycle(VEC[NV - 1 - v], 1'b1);
    repeat (40) @(posedge clk); #1;
    compare_run(BLK);
    check(overflow == 1, "R9 overflow sticky", overflow, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule